// File: doc/BRIEF.md
# Snooping Cache Line Coherence Controller

This block keeps the coherence state of a single cache line for one cache that sits on a shared snooping bus with split transactions. It screens the processor's requests against the current line state. A request that the state allows passes to the bus; any other request is refused and flagged. The block watches every bus transaction. It drives this cache's share and intervene attributes, and it moves the line state when its own transactions complete or when it observes other agents' transactions.

The bus presents one transaction per cycle with `bus_valid`. `bus_own` marks transactions that this cache initiated. The attribute inputs carry the final wired-OR values, so they already include this cache's own contribution. A split read leaves the line waiting for a matching response transaction, and only one request may be outstanding at a time. The processor can also change the line state without any bus traffic, through a separate voluntary-change input, where the protocol allows it.

Top module: `coh_line_ctrl`

## Requirements
- R1: Reset leaves the line invalid (`line_state` codes: 0 invalid, 1 shared-unmodified, 2 exclusive-unmodified, 3 exclusive-modified), not waiting, with `drv_iv` and `drv_tf` low when the bus is idle.
- R2: Request codes are 0 none, 1 read-shared, 2 read-modified, 3 invalidate, 4 copyback. The allowed requests are: from invalid, read-shared or read-modified; from shared-unmodified, read-shared, read-modified or invalidate; from either exclusive state, copyback only. When no response is awaited, an allowed request appears on `issue_cmd` in the same cycle.
- R3: A request that is not allowed, or any request made while a response is awaited, gives `issue_cmd` = 0 and `req_err` = 1. A request of 0 never sets `req_err`.
- R4: When this cache's own read-shared completes unsplit, the line becomes shared-unmodified if bus TF is high and exclusive-unmodified if it is low.
- R5: When this cache's own read-modified or invalidate completes unsplit, the line becomes exclusive-modified.
- R6: This cache's own copyback drives `drv_tf` equal to `share_keep`. It leaves the line shared-unmodified when `share_keep` is 1 and invalid when it is 0.
- R7: Bus command codes are 0 idle, 1 read-shared, 2 read-modified, 3 invalidate, 4 copyback, 5 write-invalid, 6 read-invalid, 7 shared-response, 8 modified-response. On a snooped read-shared or read-invalid, a valid line drives `drv_tf` = `share_keep` and ends shared-unmodified when it is 1, or invalid when it is 0.
- R8: A snooped read-modified, invalidate or write-invalid sends any valid line to invalid.
- R9: `drv_iv` is high only when the line is exclusive-modified and snoops read-shared, read-invalid or read-modified.
- R10: A transaction with WT high changes neither the line state nor the waiting status.
- R11: An own read-shared, read-modified or invalidate seen with SR high sets `resp_wait` and leaves the state unchanged. A later shared-response completes a waiting read-shared according to TF, as in R4. A later modified-response completes a waiting read-modified or invalidate to exclusive-modified. A shared-unmodified line that is not waiting drives `drv_tf` on a shared-response.
- R12: A voluntary change applies only from shared-unmodified to invalid, or from exclusive-unmodified to any other state. A voluntary change is ignored in every other case, and whenever the same cycle's bus transaction moves the line or carries WT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_cmd | input | 3 | Processor request code |
| share_keep | input | 1 | Processor wants to keep a shared copy (drives TF) |
| vol_en | input | 1 | Voluntary state change request |
| vol_state | input | 2 | Target state of the voluntary change |
| bus_valid | input | 1 | A bus transaction is present this cycle |
| bus_own | input | 1 | The transaction was initiated by this cache |
| bus_cmd | input | 4 | Bus command code |
| bus_sr | input | 1 | Wired-OR split attribute |
| bus_tf | input | 1 | Wired-OR share attribute, including this cache |
| bus_wt | input | 1 | Wired-OR wait attribute |
| issue_cmd | output | 3 | Request passed to the bus, 0 if refused |
| req_err | output | 1 | Request refused |
| drv_iv | output | 1 | Local intervene attribute |
| drv_tf | output | 1 | Local share attribute |
| line_state | output | 2 | Current line state |
| resp_wait | output | 1 | A split response is awaited |

## Verification
The bench targets the places where two rules meet. One is a shared-unmodified line that has issued its own read-shared and then sees the shared-response: a design that let the line assert its own TF would wrongly keep it shared instead of exclusive-unmodified. Another is a WT that arrives together with a completion or a split. A design that froze only the state and not the waiting flag would hang or complete early. The bench also checks voluntary changes that coincide with snoops, where reversed priority would resurrect a line that had just been invalidated. It checks that requests are refused while waiting; missing that check would put a second outstanding request on the bus.

// File: rtl/coh_pkg.sv
package coh_pkg;
  localparam int STATE_W = 2;
  localparam int REQ_W   = 3;
  localparam int BUS_W   = 4;

  typedef enum logic [STATE_W-1:0] {LS_INV = 2'd0, LS_SHU = 2'd1, LS_EXU = 2'd2, LS_EXM = 2'd3} line_st_t;
  typedef enum logic [REQ_W-1:0] {RQ_NONE = 3'd0, RQ_RDSH = 3'd1, RQ_RDMOD = 3'd2,
                                  RQ_INVAL = 3'd3, RQ_CPBK = 3'd4} req_t;
  typedef enum logic [BUS_W-1:0] {BC_IDLE = 4'd0, BC_RDSH = 4'd1, BC_RDMOD = 4'd2, BC_INVAL = 4'd3,
                                  BC_CPBK = 4'd4, BC_WRINV = 4'd5, BC_RDINV = 4'd6,
                                  BC_SHRSP = 4'd7, BC_MODRSP = 4'd8} bus_t;
  typedef enum logic [1:0] {PW_NONE = 2'd0, PW_SHR = 2'd1, PW_MOD = 2'd2} pend_t;

  function automatic logic req_allowed(line_st_t st, logic [REQ_W-1:0] rq);
    case (st)
      LS_INV:  return (rq == RQ_RDSH) || (rq == RQ_RDMOD);
      LS_SHU:  return (rq == RQ_RDSH) || (rq == RQ_RDMOD) || (rq == RQ_INVAL);
      default: return (rq == RQ_CPBK);
    endcase
  endfunction

  function automatic logic is_snoop_read(logic [BUS_W-1:0] bc);
    return (bc == BC_RDSH) || (bc == BC_RDINV);
  endfunction

  function automatic logic is_kill(logic [BUS_W-1:0] bc);
    return (bc == BC_RDMOD) || (bc == BC_INVAL) || (bc == BC_WRINV);
  endfunction

  function automatic logic vol_allowed(line_st_t st, line_st_t tgt);
    return ((st == LS_SHU) && (tgt == LS_INV)) || ((st == LS_EXU) && (tgt != LS_EXU));
  endfunction
endpackage

// File: rtl/coh_req_gate.sv
module coh_req_gate
  import coh_pkg::*;
(
  input  line_st_t         st,
  input  logic             waiting,
  input  logic [REQ_W-1:0] req_cmd,
  output logic [REQ_W-1:0] issue_cmd,
  output logic             req_err
);
  logic want, ok;
  always_comb begin
    want      = (req_cmd != RQ_NONE);
    ok        = want && !waiting && req_allowed(st, req_cmd);
    issue_cmd = ok ? req_cmd : RQ_NONE;
    req_err   = want && !ok;
  end
endmodule

// File: rtl/coh_snoop_unit.sv
module coh_snoop_unit
  import coh_pkg::*;
(
  input  line_st_t         st,
  input  pend_t            pend,
  input  logic             bus_valid,
  input  logic             bus_own,
  input  logic [BUS_W-1:0] bus_cmd,
  input  logic             share_keep,
  output logic             drv_iv,
  output logic             snp_tf,
  output logic             snp_hit,
  output line_st_t         snp_next
);
  logic seen, holder, rd, kill;
  always_comb begin
    seen     = bus_valid && !bus_own;
    holder   = (st != LS_INV);
    rd       = is_snoop_read(bus_cmd);
    kill     = is_kill(bus_cmd);
    drv_iv   = seen && (st == LS_EXM) && (rd || bus_cmd == BC_RDMOD);
    snp_tf   = (seen && holder && rd && share_keep) ||
               (seen && (st == LS_SHU) && (bus_cmd == BC_SHRSP) && (pend == PW_NONE));
    snp_hit  = seen && holder && (rd || kill);
    snp_next = (rd && share_keep) ? LS_SHU : LS_INV;
  end
endmodule

// File: rtl/coh_own_unit.sv
module coh_own_unit
  import coh_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  line_st_t         st,
  input  logic             bus_valid,
  input  logic             bus_own,
  input  logic [BUS_W-1:0] bus_cmd,
  input  logic             bus_sr,
  input  logic             bus_tf,
  input  logic             bus_wt,
  input  logic             share_keep,
  output pend_t            pend,
  output logic             own_tf,
  output logic             own_hit,
  output line_st_t         own_next
);
  pend_t pend_d;
  logic  live, mine, resp_sh, resp_md, split;

  always_comb begin
    live     = bus_valid && !bus_wt;
    mine     = bus_valid && bus_own;
    resp_sh  = bus_valid && !bus_own && (bus_cmd == BC_SHRSP) && (pend == PW_SHR);
    resp_md  = bus_valid && !bus_own && (bus_cmd == BC_MODRSP) && (pend == PW_MOD);
    split    = bus_sr && (bus_cmd == BC_RDSH || bus_cmd == BC_RDMOD || bus_cmd == BC_INVAL);
    own_tf   = mine && (bus_cmd == BC_CPBK) && share_keep;
    own_hit  = 1'b0;
    own_next = st;
    pend_d   = pend;
    if (mine) begin
      own_hit = (bus_cmd == BC_RDSH) || (bus_cmd == BC_RDMOD) ||
                (bus_cmd == BC_INVAL) || (bus_cmd == BC_CPBK);
      if (split) begin
        pend_d = (bus_cmd == BC_RDSH) ? PW_SHR : PW_MOD;
      end else begin
        case (bus_cmd)
          BC_RDSH:            own_next = bus_tf ? LS_SHU : LS_EXU;
          BC_RDMOD, BC_INVAL: own_next = LS_EXM;
          BC_CPBK:            own_next = share_keep ? LS_SHU : LS_INV;
          default:            own_next = st;
        endcase
      end
    end else if (resp_sh) begin
      own_hit  = 1'b1;
      own_next = bus_tf ? LS_SHU : LS_EXU;
      pend_d   = PW_NONE;
    end else if (resp_md) begin
      own_hit  = 1'b1;
      own_next = LS_EXM;
      pend_d   = PW_NONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pend <= PW_NONE;
    else if (live) pend <= pend_d;
  end

  assert_wait_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_wt) |=> $stable(pend));
  assert_split_waits_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_own && !bus_wt && bus_sr && bus_cmd == BC_RDSH) |=> (pend == PW_SHR));
endmodule

// File: rtl/coh_line_ctrl.sv
module coh_line_ctrl
  import coh_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [REQ_W-1:0]   req_cmd,
  input  logic               share_keep,
  input  logic               vol_en,
  input  logic [STATE_W-1:0] vol_state,
  input  logic               bus_valid,
  input  logic               bus_own,
  input  logic [BUS_W-1:0]   bus_cmd,
  input  logic               bus_sr,
  input  logic               bus_tf,
  input  logic               bus_wt,
  output logic [REQ_W-1:0]   issue_cmd,
  output logic               req_err,
  output logic               drv_iv,
  output logic               drv_tf,
  output logic [STATE_W-1:0] line_state,
  output logic               resp_wait
);
  line_st_t state_q, own_next, snp_next, vol_tgt;
  pend_t    pend;
  logic     own_hit, snp_hit, own_tf, snp_tf, vol_ok, frozen;

  coh_req_gate u_gate (
    .st(state_q), .waiting(pend != PW_NONE), .req_cmd(req_cmd),
    .issue_cmd(issue_cmd), .req_err(req_err));

  coh_snoop_unit u_snoop (
    .st(state_q), .pend(pend), .bus_valid(bus_valid), .bus_own(bus_own),
    .bus_cmd(bus_cmd), .share_keep(share_keep), .drv_iv(drv_iv), .snp_tf(snp_tf),
    .snp_hit(snp_hit), .snp_next(snp_next));

  coh_own_unit u_own (
    .clk(clk), .rst_n(rst_n), .st(state_q), .bus_valid(bus_valid), .bus_own(bus_own),
    .bus_cmd(bus_cmd), .bus_sr(bus_sr), .bus_tf(bus_tf), .bus_wt(bus_wt),
    .share_keep(share_keep), .pend(pend), .own_tf(own_tf), .own_hit(own_hit),
    .own_next(own_next));

  always_comb begin
    vol_tgt    = line_st_t'(vol_state);
    vol_ok     = vol_en && vol_allowed(state_q, vol_tgt);
    frozen     = bus_valid && bus_wt;
    drv_tf     = own_tf || snp_tf;
    line_state = state_q;
    resp_wait  = (pend != PW_NONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       state_q <= LS_INV;
    else if (frozen)  state_q <= state_q;
    else if (own_hit) state_q <= own_next;
    else if (snp_hit) state_q <= snp_next;
    else if (vol_ok)  state_q <= vol_tgt;
  end

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (state_q == LS_INV));
  assert_no_issue_waiting_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pend != PW_NONE) |-> (issue_cmd == RQ_NONE));
  assert_em_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != LS_EXM && !(bus_valid && !bus_wt) && !(vol_en && state_q == LS_EXU))
      |=> (state_q != LS_EXM));
  assert_iv_only_em_R9: assert property (@(posedge clk) disable iff (!rst_n)
    drv_iv |-> (state_q == LS_EXM));
  assert_wt_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_wt) |=> $stable(state_q));
endmodule

// File: tb/coh_line_ctrl_bench.sv
module coh_line_ctrl_bench;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] req_cmd = '0;
  logic share_keep = 1'b0, vol_en = 1'b0;
  logic [1:0] vol_state = '0;
  logic bus_valid = 1'b0, bus_own = 1'b0, bus_sr = 1'b0, bus_tf = 1'b0, bus_wt = 1'b0;
  logic [3:0] bus_cmd = '0;
  logic [2:0] issue_cmd;
  logic req_err, drv_iv, drv_tf, resp_wait;
  logic [1:0] line_state;

  int n_chk = 0, n_err = 0;
  int m_st = 0, m_pend = 0;
  string m_tag = "R1";
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  coh_line_ctrl u_coh_line_ctrl (
    .clk(clk), .rst_n(rst_n), .req_cmd(req_cmd), .share_keep(share_keep),
    .vol_en(vol_en), .vol_state(vol_state), .bus_valid(bus_valid), .bus_own(bus_own),
    .bus_cmd(bus_cmd), .bus_sr(bus_sr), .bus_tf(bus_tf), .bus_wt(bus_wt),
    .issue_cmd(issue_cmd), .req_err(req_err), .drv_iv(drv_iv), .drv_tf(drv_tf),
    .line_state(line_state), .resp_wait(resp_wait));

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic bit b_legal(int st, int rq);
    if (st == 0) return rq == 1 || rq == 2;
    if (st == 1) return rq >= 1 && rq <= 3;
    return rq == 4;
  endfunction

  // One bus cycle: drive at the falling edge, check combinational outputs,
  // advance the model, then check registered outputs at the next falling edge.
  task automatic cyc(input int rq, input bit keep, input bit ven, input int vtg,
                     input bit bv, input bit own, input int cmd, input bit sr,
                     input bit wt, input bit otf);
    bit lg, snp, rd, kill, e_iv, e_tf, btf;
    int e_issue, ns, np;
    string tg;
    lg = (rq != 0) && b_legal(m_st, rq) && (m_pend == 0);
    e_issue = lg ? rq : 0;
    snp  = bv && !own;
    rd   = (cmd == 1) || (cmd == 6);
    kill = (cmd == 2) || (cmd == 3) || (cmd == 5);
    e_iv = snp && (m_st == 3) && (rd || cmd == 2);
    e_tf = (snp && m_st != 0 && rd && keep) || (snp && m_st == 1 && cmd == 7 && m_pend == 0) ||
           (bv && own && cmd == 4 && keep);
    btf = otf | e_tf;
    req_cmd = rq[2:0]; share_keep = keep; vol_en = ven; vol_state = vtg[1:0];
    bus_valid = bv; bus_own = own; bus_cmd = cmd[3:0]; bus_sr = sr; bus_wt = wt; bus_tf = btf;
    #1;
    chk(issue_cmd == e_issue, "R2", "issue_cmd", issue_cmd, e_issue);
    chk(req_err == (rq != 0 && !lg), "R3", "req_err", req_err, rq != 0 && !lg);
    chk(drv_iv == e_iv, "R9", "drv_iv", drv_iv, e_iv);
    chk(drv_tf == e_tf, "R7", "drv_tf", drv_tf, e_tf);
    ns = m_st; np = m_pend; tg = "R12";
    if (bv && wt) tg = "R10";
    else if (bv && own && cmd >= 1 && cmd <= 4) begin
      if (sr && cmd != 4) begin np = (cmd == 1) ? 1 : 2; tg = "R11"; end
      else if (cmd == 1) begin ns = btf ? 1 : 2; tg = "R4"; end
      else if (cmd == 4) begin ns = keep ? 1 : 0; tg = "R6"; end
      else begin ns = 3; tg = "R5"; end
    end else if (snp && cmd == 7 && m_pend == 1) begin ns = btf ? 1 : 2; np = 0; tg = "R11"; end
    else if (snp && cmd == 8 && m_pend == 2) begin ns = 3; np = 0; tg = "R11"; end
    else if (snp && m_st != 0 && rd) begin ns = keep ? 1 : 0; tg = "R7"; end
    else if (snp && m_st != 0 && kill) begin ns = 0; tg = "R8"; end
    else if (ven && ((m_st == 1 && vtg == 0) || (m_st == 2 && vtg != 2))) ns = vtg;
    m_st = ns; m_pend = np; m_tag = tg;
    @(negedge clk);
    chk(line_state == m_st, m_tag, "line_state", line_state, m_st);
    chk(resp_wait == (m_pend != 0), "R11", "resp_wait", resp_wait, m_pend != 0);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual 0 expected 1 (run completed)");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(line_state == 0, "R1", "reset line_state", line_state, 0);
    chk(resp_wait == 0, "R1", "reset resp_wait", resp_wait, 0);
    chk(drv_iv == 0 && drv_tf == 0, "R1", "reset drives", drv_iv + drv_tf, 0);
    // Directed corner cases
    cyc(4, 0, 0, 0, 0, 0, 0, 0, 0, 0);      // R3 copyback from invalid refused
    cyc(1, 0, 0, 0, 1, 1, 1, 0, 0, 0);      // R4 read-shared, no TF -> EU
    cyc(0, 1, 0, 0, 1, 0, 1, 0, 0, 0);      // R7 EU snoops read, keeps -> SU
    cyc(3, 0, 0, 0, 1, 1, 3, 0, 1, 0);      // R10 invalidate with WT: frozen
    cyc(3, 0, 1, 0, 1, 1, 3, 0, 0, 0);      // R5 invalidate completes -> EM, vol ignored
    cyc(0, 0, 0, 0, 1, 0, 2, 0, 0, 0);      // R9 EM snoops read-modified -> iv, invalid
    cyc(1, 0, 0, 0, 1, 1, 1, 1, 0, 0);      // R11 split read-shared
    cyc(1, 0, 0, 0, 1, 0, 7, 0, 1, 0);      // R10 response with WT held off
    cyc(1, 0, 0, 0, 1, 0, 7, 0, 0, 1);      // R11 shared-response, TF -> SU
    cyc(1, 0, 0, 0, 1, 1, 1, 1, 0, 0);      // R11 SU splits own read-shared
    cyc(0, 1, 0, 0, 1, 0, 7, 0, 0, 0);      // R11 SU waiting does not assert TF -> EU
    cyc(0, 0, 1, 3, 1, 0, 4, 0, 0, 0);      // R12 EU -> EM voluntarily beside copyback snoop
    cyc(4, 1, 0, 0, 1, 1, 4, 0, 0, 0);      // R6 copyback keep -> SU
    cyc(0, 0, 1, 2, 0, 0, 0, 0, 0, 0);      // R12 SU -> EU refused
    cyc(0, 0, 1, 0, 1, 0, 5, 0, 0, 0);      // R8 write-invalid wins over vol
    for (int i = 0; i < 4000; i++) begin
      int rq, vtg, r, cmd;
      bit keep, ven, lg, bv, own, sr, wt, otf;
      rq = $urandom_range(0, 4); keep = 1'($urandom_range(0, 1));
      ven = ($urandom_range(0, 7) == 0); vtg = $urandom_range(0, 3);
      lg = (rq != 0) && b_legal(m_st, rq) && (m_pend == 0);
      r = $urandom_range(0, 9);
      bv = 0; own = 0; cmd = 0; sr = 0; wt = 0;
      if (lg && r < 5) begin
        bv = 1; own = 1; cmd = rq; sr = ($urandom_range(0, 4) == 0); wt = ($urandom_range(0, 7) == 0);
      end else if (r < 8) begin
        bv = 1; wt = ($urandom_range(0, 7) == 0);
        if (m_pend != 0 && $urandom_range(0, 1) == 1) cmd = (m_pend == 1) ? 7 : 8;
        else cmd = $urandom_range(0, 8);
      end
      otf = ($urandom_range(0, 2) == 0);
      cyc(rq, keep, ven, vtg, bv, own, cmd, sr, wt, otf);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule